// File: doc/BRIEF.md
# Periodic Burst Data-Valid Generator

This block drives a byte stream with a qualifying strobe whose on/off pattern follows a fixed, two-level schedule. A frame holds a number of bursts. During a burst the strobe is high on every clock, and each burst is followed by a short gap with the strobe low. After the gap that follows the final burst comes one long idle stretch, and then the frame starts again. This repeats for as long as the block runs. The block serves as stimulus for rate-recovery logic, such as a buffer whose drain rate must track the long-term average of its fill rate, or as a traffic shaper that paces a downstream consumer.

The bytes are produced by an internal counter that advances only on qualified cycles. A downstream checker can therefore confirm byte order and detect lost or duplicated bytes across bursts and frames. A one-clock marker flags the first cycle of every frame. All run lengths are parameters. By default the schedule is three bursts of 6250 clocks, each followed by a 3750-clock gap, and then a 30000-clock idle stretch.

Top module: `burst_sched_gen`

## Requirements
- R1: While `rst_i` is high, all outputs are held low and `data_o` is zero. On the first clock after `rst_i` falls, the outputs show the first cycle of burst one: `valid_o`=1, `frame_start_o`=1, `data_o`=0.
- R2: Each burst holds `valid_o` high for exactly `BURST_LEN` consecutive clocks (default 6250).
- R3: Each burst is followed by exactly `GAP_LEN` clocks with `valid_o` low (default 3750).
- R4: A frame contains `BURSTS` burst-plus-gap pairs (default 3). The last gap is followed by a further `IDLE_LEN` low clocks (default 30000). With the defaults, a frame lasts 60000 clocks and carries 18750 qualified bytes.
- R5: The frame repeats without end. The cycle after the idle stretch starts burst one of the next frame.
- R6: The payload byte is 0 on the first qualified cycle after reset. It then rises by one on each later qualified cycle, wraps from 255 to 0, and does not advance on unqualified cycles.
- R7: `data_o` is zero on every cycle where `valid_o` is low.
- R8: `frame_start_o` is high for exactly one clock, on the first cycle of each frame, which is also the first qualified cycle of burst one.
- R9: Asserting `rst_i` partway through a frame restarts the schedule and the payload from the beginning, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one schedule position per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_o | output | 1 | High during burst windows only |
| data_o | output | DATA_W | Payload byte, zero outside bursts |
| frame_start_o | output | 1 | One-clock marker on the first cycle of a frame |

## Verification
The block has no data inputs, so the properties assume only that `rst_i` is held for at least one edge at start-up and is changed away from the active edge. The run-length and payload properties are measured from the most recent reset, so they assume that every run they judge began after that reset. The bench meets these assumptions by driving `rst_i` on falling edges only and holding it for several cycles. It runs a small configuration through a payload wrap and a reset in the middle of a frame, and runs the default configuration through two full frames.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

  typedef enum logic [1:0] {
    PH_BURST = 2'd0,
    PH_GAP   = 2'd1,
    PH_IDLE  = 2'd2
  } phase_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/burst_run_timer.sv
// Counts clocks within the current run and flags its last clock.
module burst_run_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             first_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o  = (cnt_q == len_m1_i);
  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i || wrap_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/burst_phase_seq.sv
// Walks burst -> gap (repeated) -> idle -> burst and supplies each run length.
module burst_phase_seq
  import burst_sched_pkg::*;
#(
  parameter int BURST_LEN = 6250,
  parameter int GAP_LEN   = 3750,
  parameter int IDLE_LEN  = 30000,
  parameter int BURSTS    = 3,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wrap_i,
  input  logic             first_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] len_m1_o,
  output logic             frame_first_o
);

  localparam bit HAS_IDLE = (IDLE_LEN > 0);
  localparam int IDLE_M1  = HAS_IDLE ? IDLE_LEN - 1 : 0;

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_burst;

  assign last_burst = (idx_q == IDX_W'(BURSTS - 1));

  always_comb begin
    unique case (phase_q)
      PH_BURST: len_m1_o = CNT_W'(BURST_LEN - 1);
      PH_GAP:   len_m1_o = CNT_W'(GAP_LEN - 1);
      default:  len_m1_o = CNT_W'(IDLE_M1);
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (wrap_i) begin
      unique case (phase_q)
        PH_BURST: phase_d = PH_GAP;
        PH_GAP: begin
          if (!last_burst) begin
            phase_d = PH_BURST;
            idx_d   = idx_q + 1'b1;
          end else if (HAS_IDLE) begin
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_BURST;
            idx_d   = '0;
          end
        end
        default: begin
          phase_d = PH_BURST;
          idx_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_BURST;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase_o       = phase_q;
  assign frame_first_o = (phase_q == PH_BURST) && (idx_q == '0) && first_i;

endmodule

// File: rtl/burst_payload_ctr.sv
// Free-running payload counter that advances only on qualified cycles.
module burst_payload_ctr #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] value_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i)      value_o <= '0;
    else if (adv_i) value_o <= value_o + 1'b1;
  end

endmodule

// File: rtl/burst_sched_gen.sv
module burst_sched_gen
  import burst_sched_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 6250,
  parameter int GAP_LEN   = 3750,
  parameter int IDLE_LEN  = 30000,
  parameter int BURSTS    = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_start_o
);

  localparam int MAX_LEN = int'(max3(BURST_LEN, GAP_LEN, IDLE_LEN));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = (BURSTS > 1) ? $clog2(BURSTS) : 1;

  phase_e            phase;
  logic [CNT_W-1:0]  len_m1;
  logic              run_wrap;
  logic              run_first;
  logic              frame_first;
  logic              in_burst;
  logic [DATA_W-1:0] payload;

  burst_run_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .len_m1_i (len_m1),
    .first_o  (run_first),
    .wrap_o   (run_wrap)
  );

  burst_phase_seq #(
    .BURST_LEN (BURST_LEN),
    .GAP_LEN   (GAP_LEN),
    .IDLE_LEN  (IDLE_LEN),
    .BURSTS    (BURSTS),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .wrap_i        (run_wrap),
    .first_i       (run_first),
    .phase_o       (phase),
    .len_m1_o      (len_m1),
    .frame_first_o (frame_first)
  );

  assign in_burst = (phase == PH_BURST);

  burst_payload_ctr #(.DATA_W(DATA_W)) u_payload (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (in_burst),
    .value_o (payload)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o       <= 1'b0;
      data_o        <= '0;
      frame_start_o <= 1'b0;
    end else begin
      valid_o       <= in_burst;
      data_o        <= in_burst ? payload : '0;
      frame_start_o <= frame_first;
    end
  end

endmodule

// File: rtl/burst_sched_gen_chk.sv
module burst_sched_gen_chk #(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 6250,
  parameter int GAP_LEN   = 3750,
  parameter int IDLE_LEN  = 30000,
  parameter int BURSTS    = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              frame_start_o
);

  logic [31:0]       hi_cnt, lo_cnt, burst_cnt;
  logic              seen_hi, have_last, prev_valid;
  logic [DATA_W-1:0] last_data;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      burst_cnt  <= '0;
      seen_hi    <= 1'b0;
      have_last  <= 1'b0;
      prev_valid <= 1'b0;
      last_data  <= '0;
    end else begin
      prev_valid <= valid_o;
      hi_cnt     <= valid_o ? hi_cnt + 1 : '0;
      lo_cnt     <= valid_o ? '0 : lo_cnt + 1;
      if (valid_o) begin
        seen_hi   <= 1'b1;
        have_last <= 1'b1;
        last_data <= data_o;
      end
      if (valid_o && !prev_valid)
        burst_cnt <= frame_start_o ? 32'd1 : burst_cnt + 1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && !frame_start_o && data_o == '0));

  p_restart_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |=> (frame_start_o && valid_o && data_o == '0));

  p_burst_len_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(valid_o) |-> (hi_cnt == 32'(BURST_LEN)));

  p_gap_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(valid_o) && seen_hi) |->
      (lo_cnt == 32'(GAP_LEN) || lo_cnt == 32'(GAP_LEN + IDLE_LEN)));

  p_idle_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_start_o && seen_hi) |-> (lo_cnt == 32'(GAP_LEN + IDLE_LEN)));

  p_burst_count_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_start_o && seen_hi) |-> (burst_cnt == 32'(BURSTS)));

  p_payload_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && have_last) |-> (data_o == DATA_W'(last_data + 1'b1)));

  p_data_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> (data_o == '0));

  p_marker_in_burst_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> valid_o);

  p_marker_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |=> !frame_start_o);

endmodule

bind burst_sched_gen burst_sched_gen_chk #(
  .DATA_W    (DATA_W),
  .BURST_LEN (BURST_LEN),
  .GAP_LEN   (GAP_LEN),
  .IDLE_LEN  (IDLE_LEN),
  .BURSTS    (BURSTS)
) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .valid_o       (valid_o),
  .data_o        (data_o),
  .frame_start_o (frame_start_o)
);

// File: tb/burst_sched_gen_bench.sv
`timescale 1ns/1ps
module burst_sched_gen_bench;

  // small configuration: frame = 3*(4+2)+5 = 23 clocks, 12 bytes
  localparam int SB = 4, SG = 2, SI = 5, SN = 3;
  localparam int DB = 6250, DG = 3750, DI = 30000, DN = 3;

  typedef struct packed {
    int       pos;
    bit       v;
    bit [7:0] d;
    bit       f;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{pos: 0,  v: 1'b1, d: 8'd0,  f: 1'b1},
    '{pos: 3,  v: 1'b1, d: 8'd3,  f: 1'b0},
    '{pos: 4,  v: 1'b0, d: 8'd0,  f: 1'b0},
    '{pos: 5,  v: 1'b0, d: 8'd0,  f: 1'b0},
    '{pos: 6,  v: 1'b1, d: 8'd4,  f: 1'b0},
    '{pos: 11, v: 1'b0, d: 8'd0,  f: 1'b0},
    '{pos: 12, v: 1'b1, d: 8'd8,  f: 1'b0},
    '{pos: 15, v: 1'b1, d: 8'd11, f: 1'b0},
    '{pos: 17, v: 1'b0, d: 8'd0,  f: 1'b0},
    '{pos: 18, v: 1'b0, d: 8'd0,  f: 1'b0},
    '{pos: 22, v: 1'b0, d: 8'd0,  f: 1'b0},
    '{pos: 23, v: 1'b1, d: 8'd12, f: 1'b1},
    '{pos: 24, v: 1'b1, d: 8'd13, f: 1'b0},
    '{pos: 46, v: 1'b1, d: 8'd24, f: 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_s = 1'b1, rst_d = 1'b1;
  logic       v_s, f_s, v_d, f_d;
  logic [7:0] d_s, d_d;

  int checks = 0, errors = 0;
  int pos_s = -1, pos_d = -1;
  int vcount_d = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_sched_gen #(.DATA_W(8), .BURST_LEN(SB), .GAP_LEN(SG), .IDLE_LEN(SI), .BURSTS(SN))
    u_burst_sched_gen_small (.clk_i(clk), .rst_i(rst_s), .valid_o(v_s), .data_o(d_s), .frame_start_o(f_s));

  burst_sched_gen u_burst_sched_gen (
    .clk_i(clk), .rst_i(rst_d), .valid_o(v_d), .data_o(d_d), .frame_start_o(f_d));

  always @(posedge clk) begin
    pos_s = rst_s ? -1 : pos_s + 1;
    pos_d = rst_d ? -1 : pos_d + 1;
  end

  function automatic bit m_valid(int p, int b, int g, int n, int i);
    int f = n * (b + g) + i;
    int q = p % f;
    return (q < n * (b + g)) && ((q % (b + g)) < b);
  endfunction

  function automatic bit [7:0] m_data(int p, int b, int g, int n, int i);
    int f = n * (b + g) + i;
    int q = p % f;
    int vb;
    if (!m_valid(p, b, g, n, i)) return 8'd0;
    vb = (p / f) * n * b + (q / (b + g)) * b + (q % (b + g));
    return vb[7:0];
  endfunction

  function automatic bit m_fs(int p, int b, int g, int n, int i);
    return (p % (n * (b + g) + i)) == 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // continuous comparison against the schedule model
  always @(negedge clk) begin
    if (!done && pos_s >= 0) begin
      check(v_s == m_valid(pos_s, SB, SG, SN, SI), "R2/R3/R4 small valid", v_s, m_valid(pos_s, SB, SG, SN, SI));
      check(d_s == m_data(pos_s, SB, SG, SN, SI), "R6/R7 small data", d_s, m_data(pos_s, SB, SG, SN, SI));
      check(f_s == m_fs(pos_s, SB, SG, SN, SI), "R8 small frame_start", f_s, m_fs(pos_s, SB, SG, SN, SI));
    end
    if (!done && pos_d >= 0) begin
      check(v_d == m_valid(pos_d, DB, DG, DN, DI), "R2/R3/R4 default valid", v_d, m_valid(pos_d, DB, DG, DN, DI));
      check(d_d == m_data(pos_d, DB, DG, DN, DI), "R6/R7 default data", d_d, m_data(pos_d, DB, DG, DN, DI));
      check(f_d == m_fs(pos_d, DB, DG, DN, DI), "R8/R5 default frame_start", f_d, m_fs(pos_d, DB, DG, DN, DI));
      if (pos_d < 60000 && v_d) vcount_d++;
    end
  end

  task automatic wait_small(int p);
    while (pos_s != p) @(negedge clk);
  endtask

  task automatic wait_default(int p);
    while (pos_d != p) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(v_s == 1'b0 && f_s == 1'b0 && d_s == 8'd0, "R1 reset outputs", {v_s, f_s}, 0);
    rst_s = 1'b0;

    // table walk on the small configuration (R2, R3, R4, R5, R6, R8)
    foreach (TBL[i]) begin
      wait_small(TBL[i].pos);
      check(v_s == TBL[i].v, "R2/R3 table valid", v_s, TBL[i].v);
      check(d_s == TBL[i].d, "R6/R7 table data", d_s, TBL[i].d);
      check(f_s == TBL[i].f, "R8/R5 table frame_start", f_s, TBL[i].f);
    end

    // R6: payload wrap 255 -> 0 (byte 256 is at position 489)
    wait_small(486);
    check(v_s && d_s == 8'd255, "R6 byte before wrap", d_s, 255);
    wait_small(489);
    check(v_s && d_s == 8'd0, "R6 byte after wrap", d_s, 0);

    // R9: reset in the middle of a frame
    wait_small(500);
    rst_s = 1'b1;
    @(negedge clk);
    check(!v_s && !f_s && d_s == 8'd0, "R9 outputs cleared by reset", {v_s, f_s}, 0);
    @(negedge clk);
    rst_s = 1'b0;
    wait_small(0);
    check(v_s && f_s && d_s == 8'd0, "R9 restart at burst one", {v_s, f_s}, 3);
    wait_small(60);

    // default configuration: two full frames
    rst_d = 1'b0;
    wait_default(0);
    check(v_d && f_d && d_d == 8'd0, "R1 default first cycle", {v_d, f_d}, 3);
    wait_default(6250);
    check(!v_d, "R2 default burst ends after 6250", v_d, 0);
    wait_default(59999);
    check(!v_d && !f_d, "R4 default idle at frame end", v_d, 0);
    wait_default(60000);
    check(vcount_d == 18750, "R4 default bytes per frame", vcount_d, 18750);
    check(f_d && v_d, "R5 default frame repeats", f_d, 1);
    check(d_d == 8'(18750), "R6 default payload carries across frame", d_d, 18750 % 256);
    wait_default(120001);
    finish_run();
  end

endmodule